// File: doc/BRIEF.md
# Power domain collapse sequencer

This block switches one logic power domain on and off under the control of a small register port. Powering down, it walks five control outputs through a fixed order: the domain clock is gated first, then the outputs of the domain are clamped, state retention is asserted if it is enabled, the domain reset is asserted, and last the power switch enable is dropped. Powering up runs the same five steps in mirror order. Each step is followed by a programmable wait of `wait + 1` clocks. The first power-up step also holds until the switch acknowledge input is high. The analog switch itself lies outside the block; `sw_ack` stands in for it.

The target state comes from one of two owners, chosen at run time. In software mode a collapse bit in the control register sets the target. In hardware mode the `hw_collapse_req` input sets it; that input is synchronous to `clk`. A hold bit freezes the sequencer in its current stable state. A request that changes while a sequence is running is acted on only once the running sequence reaches a stable on or off state. Software learns the result from a live power-on bit and from separate up-complete and down-complete flags.

Top module: `pwr_collapse_seq`

## Requirements
- R1: After reset the control word at offset 0 reads 0x0000_2001: collapse bit 0 = 1, hardware-select bit 1 = 0, hold bit 2 = 0, retain bit 11 = 0, wait field bits 15:12 = 2 and power-on bit 31 = 0. The outputs are in the off state: switch 0, clamp 1, reset 1, clock enable 0, retain 0.
- R2: In software mode, writing the collapse bit as 0 powers the domain up and writing it as 1 powers it down.
- R3: A power-down changes clock enable, clamp, retain, reset and then switch enable, in that order. Successive changes lie exactly wait+1 clocks apart. Down-complete sets 1 + 5*(wait+1) clocks after the write edge.
- R4: A power-up runs in the mirror order: switch on, reset release, retain release, clamp release, clock on. With the acknowledge already high, up-complete sets 1 + 5*(wait+1) clocks after the write edge. While `sw_ack` is low, the reset stays asserted and no flag is set.
- R5: The retain output rises during a power-down only when retain bit 11 is set, and it is released in the power-up step after reset release.
- R6: The status word at offset 4 carries up-complete at bit 16 and down-complete at bit 15. The two are never set together, and neither is set while a sequence runs. Bit 31 of the control word equals up-complete.
- R7: When bit 1 is set, `hw_collapse_req` (1 = collapse) decides the target state and the collapse bit has no effect.
- R8: While hold bit 2 is set, no new sequence starts from a stable state. Clearing the bit lets the pending request proceed.
- R9: A request that changes during a running sequence does not cut that sequence short. The sequence completes, and the new target is then carried out.
- R10: Bits 0, 1, 2, 11 and 15:12 read back as written, and bit 31 ignores write data. Writes to offset 4 change nothing.
- R11: A switch of owner whose target disagrees with the current state drives a full collapse. If the target returns, the domain is restored. The power-on bit stays 0 from the switch until the restore completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (3) | Byte address; bit 2 selects the word |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr` |
| hw_collapse_req | input | 1 | Hardware owner's collapse request |
| sw_ack | input | 1 | Power switch acknowledge |
| pwr_switch_en | output | 1 | Power switch enable |
| clamp_en | output | 1 | Domain output clamp |
| domain_rst | output | 1 | Domain reset |
| clk_en | output | 1 | Domain clock enable |
| retain_en | output | 1 | Flip-flop retention control |

## Verification
The bench times each output edge against the write edge. A sequencer that reordered steps, or that dropped a wait state, would move one of these edges by at least one clock. It stalls the acknowledge to catch a design that releases reset before the switch settles. It changes the request in the middle of a sequence to catch a design that reverses direction part-way and leaves clamp or reset in a mixed state. It also flips ownership against the live state. A design that raised the power-on bit early, or ignored the trigger, would show power-on high with the switch never having dropped.

// File: rtl/pds_pkg.sv
package pds_pkg;
  // Field positions decoded by software; these must not move.
  localparam int CTL_COLLAPSE = 0;
  localparam int CTL_HWSEL    = 1;
  localparam int CTL_HOLD     = 2;
  localparam int CTL_RETAIN   = 11;
  localparam int CTL_WAIT_LSB = 12;
  localparam int CTL_PWRON    = 31;
  localparam int ST_DN_DONE   = 15;
  localparam int ST_UP_DONE   = 16;

  // Number of sequencing steps in each direction.
  localparam int NSTEPS = 5;

  typedef enum logic [1:0] {PH_OFF, PH_DN, PH_UP, PH_ON} phase_t;

  typedef struct packed {
    logic sw_en;
    logic clamp;
    logic rst;
    logic clk_en;
    logic retain;
  } dom_ctl_t;

  localparam dom_ctl_t DOM_OFF = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
endpackage

// File: rtl/pds_rst_sync.sv
module pds_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/pds_regs.sv
module pds_regs
  import pds_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3,
  parameter int WAIT_W   = 4,
  parameter int WAIT_RST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pwr_on,
  input  logic              up_done,
  input  logic              dn_done,
  output logic              collapse,
  output logic              hw_sel,
  output logic              hold,
  output logic              retain_cfg,
  output logic [WAIT_W-1:0] wait_val,
  output logic [DATA_W-1:0] rdata
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam logic [WIDX_W-1:0] W_CTL = WIDX_W'(0);
  localparam logic [WIDX_W-1:0] W_ST  = WIDX_W'(1);

  logic [WIDX_W-1:0] word;
  logic              ctl_wr;
  logic              collapse_q, collapse_n;
  logic              hwsel_q, hwsel_n;
  logic              hold_q, hold_n;
  logic              retain_q, retain_n;
  logic [WAIT_W-1:0] wait_q, wait_n;
  logic              unused_bits;

  assign word   = addr[ADDR_W-1:2];
  assign ctl_wr = we && (word == W_CTL);

  always_comb begin
    collapse_n = collapse_q;
    hwsel_n    = hwsel_q;
    hold_n     = hold_q;
    retain_n   = retain_q;
    wait_n     = wait_q;
    if (ctl_wr) begin
      collapse_n = wdata[CTL_COLLAPSE];
      hwsel_n    = wdata[CTL_HWSEL];
      hold_n     = wdata[CTL_HOLD];
      retain_n   = wdata[CTL_RETAIN];
      wait_n     = wdata[CTL_WAIT_LSB +: WAIT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      collapse_q <= 1'b1;
      hwsel_q    <= 1'b0;
      hold_q     <= 1'b0;
      retain_q   <= 1'b0;
      wait_q     <= WAIT_W'(WAIT_RST);
    end else if (ctl_wr) begin
      collapse_q <= collapse_n;
      hwsel_q    <= hwsel_n;
      hold_q     <= hold_n;
      retain_q   <= retain_n;
      wait_q     <= wait_n;
    end
  end

  always_comb begin
    rdata = '0;
    if (word == W_CTL) begin
      rdata[CTL_COLLAPSE]             = collapse_q;
      rdata[CTL_HWSEL]                = hwsel_q;
      rdata[CTL_HOLD]                 = hold_q;
      rdata[CTL_RETAIN]               = retain_q;
      rdata[CTL_WAIT_LSB +: WAIT_W]   = wait_q;
      rdata[CTL_PWRON]                = pwr_on;
    end else if (word == W_ST) begin
      rdata[ST_DN_DONE] = dn_done;
      rdata[ST_UP_DONE] = up_done;
    end
  end

  assign collapse   = collapse_q;
  assign hw_sel     = hwsel_q;
  assign hold       = hold_q;
  assign retain_cfg = retain_q;
  assign wait_val   = wait_q;
  assign unused_bits = ^{addr[1:0], wdata};
endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
  import pds_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              target_off,
  input  logic              hold,
  input  logic              sw_ack,
  input  logic [WAIT_W-1:0] wait_val,
  input  logic              retain_cfg,
  output dom_ctl_t          ctl,
  output phase_t            phase
);
  localparam int STEP_W = $clog2(NSTEPS);
  localparam logic [STEP_W-1:0] LAST_S = STEP_W'(NSTEPS - 1);

  phase_t            phase_q, phase_n;
  logic [STEP_W-1:0] step_q, step_n;
  logic [WAIT_W-1:0] cnt_q, cnt_n;
  dom_ctl_t          ctl_q, ctl_n;
  logic              upd;

  // One step table; power-up walks it from the far end.
  function automatic dom_ctl_t step_apply(input dom_ctl_t cur, input logic down,
                                          input logic [STEP_W-1:0] idx,
                                          input logic ret);
    dom_ctl_t r;
    logic [STEP_W-1:0] k;
    r = cur;
    k = down ? idx : (LAST_S - idx);
    case (k)
      STEP_W'(0): r.clk_en = !down;
      STEP_W'(1): r.clamp  = down;
      STEP_W'(2): r.retain = down & ret;
      STEP_W'(3): r.rst    = down;
      default:    r.sw_en  = !down;
    endcase
    return r;
  endfunction

  always_comb begin
    phase_n = phase_q;
    step_n  = step_q;
    cnt_n   = cnt_q;
    ctl_n   = ctl_q;
    case (phase_q)
      PH_OFF: begin
        if (!hold && !target_off) begin
          phase_n = PH_UP;
          step_n  = '0;
          cnt_n   = wait_val;
          ctl_n   = step_apply(ctl_q, 1'b0, '0, retain_cfg);
        end
      end
      PH_ON: begin
        if (!hold && target_off) begin
          phase_n = PH_DN;
          step_n  = '0;
          cnt_n   = wait_val;
          ctl_n   = step_apply(ctl_q, 1'b1, '0, retain_cfg);
        end
      end
      default: begin
        if (cnt_q != '0) begin
          cnt_n = cnt_q - 1'b1;
        end else if (phase_q == PH_UP && step_q == '0 && !sw_ack) begin
          cnt_n = cnt_q;
        end else if (step_q == LAST_S) begin
          phase_n = (phase_q == PH_UP) ? PH_ON : PH_OFF;
        end else begin
          step_n = step_q + 1'b1;
          cnt_n  = wait_val;
          ctl_n  = step_apply(ctl_q, phase_q == PH_DN, step_q + 1'b1, retain_cfg);
        end
      end
    endcase
  end

  // Clock enable: registers only move when something changes.
  assign upd = (phase_n != phase_q) || (step_n != step_q) ||
               (cnt_n != cnt_q) || (ctl_n != ctl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OFF;
      step_q  <= '0;
      cnt_q   <= '0;
      ctl_q   <= DOM_OFF;
    end else if (upd) begin
      phase_q <= phase_n;
      step_q  <= step_n;
      cnt_q   <= cnt_n;
      ctl_q   <= ctl_n;
    end
  end

  assign ctl   = ctl_q;
  assign phase = phase_q;
endmodule

// File: rtl/pwr_collapse_seq.sv
module pwr_collapse_seq
  import pds_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3,
  parameter int WAIT_W     = 4,
  parameter int WAIT_RST   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              hw_collapse_req,
  input  logic              sw_ack,
  output logic              pwr_switch_en,
  output logic              clamp_en,
  output logic              domain_rst,
  output logic              clk_en,
  output logic              retain_en
);
  logic              rst_sync_n;
  logic              cfg_collapse, cfg_hwsel, cfg_hold, cfg_retain;
  logic [WAIT_W-1:0] cfg_wait;
  logic              target_off;
  phase_t            fsm_phase;
  dom_ctl_t          dom;
  logic              st_on, st_off;

  pds_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pds_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .WAIT_RST(WAIT_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .pwr_on(st_on), .up_done(st_on), .dn_done(st_off),
    .collapse(cfg_collapse), .hw_sel(cfg_hwsel), .hold(cfg_hold),
    .retain_cfg(cfg_retain), .wait_val(cfg_wait), .rdata(reg_rdata)
  );

  // Owner select: hardware trigger or software collapse bit.
  assign target_off = cfg_hwsel ? hw_collapse_req : cfg_collapse;

  pds_fsm #(.WAIT_W(WAIT_W)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n),
    .target_off(target_off), .hold(cfg_hold), .sw_ack(sw_ack),
    .wait_val(cfg_wait), .retain_cfg(cfg_retain),
    .ctl(dom), .phase(fsm_phase)
  );

  assign st_on  = (fsm_phase == PH_ON);
  assign st_off = (fsm_phase == PH_OFF);

  assign pwr_switch_en = dom.sw_en;
  assign clamp_en      = dom.clamp;
  assign domain_rst    = dom.rst;
  assign clk_en        = dom.clk_en;
  assign retain_en     = dom.retain;
endmodule

// File: rtl/pwr_collapse_seq_chk.sv
module pwr_collapse_seq_chk
  import pds_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   pwr_switch_en,
  input logic   clamp_en,
  input logic   domain_rst,
  input logic   clk_en,
  input logic   retain_en,
  input logic   sw_ack,
  input logic   hold,
  input logic   retain_cfg,
  input phase_t phase
);
  // R3: the clock never runs into a clamped domain
  a_r3_clk_off_while_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_en |-> !clk_en);

  // R3: the switch is off only behind clamp and reset
  a_r3_switch_off_safe: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_switch_en |-> (clamp_en && domain_rst && !clk_en));

  // R4: reset is released only after the switch acknowledged
  a_r4_release_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(domain_rst) |-> $past(sw_ack));

  // R5: retention rises only when enabled
  a_r5_retain_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retain_en) |-> $past(retain_cfg));

  // R6: the on state means every output is in its running value
  a_r6_on_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ON) |-> (pwr_switch_en && clk_en && !clamp_en && !domain_rst && !retain_en));

  // R8: hold keeps a powered domain where it is
  a_r8_hold_keeps_on: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hold) && $past(phase == PH_ON)) |-> (phase == PH_ON));
endmodule

bind pwr_collapse_seq pwr_collapse_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .pwr_switch_en(pwr_switch_en), .clamp_en(clamp_en), .domain_rst(domain_rst),
  .clk_en(clk_en), .retain_en(retain_en), .sw_ack(sw_ack),
  .hold(cfg_hold), .retain_cfg(cfg_retain), .phase(fsm_phase)
);

// File: tb/pwr_collapse_seq_test.sv
`timescale 1ns/1ps
module pwr_collapse_seq_test;
  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        hw_collapse_req;
  logic        sw_ack;
  logic        pwr_switch_en, clamp_en, domain_rst, clk_en, retain_en;
  logic        ack_block;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  // Monitor state: cycle stamps of each output edge
  int t_sw_r, t_sw_f, t_rst_r, t_rst_f, t_cl_r, t_cl_f, t_ck_r, t_ck_f, t_rt_r, t_rt_f;
  int rt_high = 0;
  int both_flags = 0;
  logic p_sw, p_rst, p_cl, p_ck, p_rt;

  pwr_collapse_seq uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hw_collapse_req(hw_collapse_req), .sw_ack(sw_ack),
    .pwr_switch_en(pwr_switch_en), .clamp_en(clamp_en), .domain_rst(domain_rst),
    .clk_en(clk_en), .retain_en(retain_en)
  );

  assign sw_ack = pwr_switch_en && !ack_block;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pwr_switch_en && !p_sw) t_sw_r = cyc;
      if (!pwr_switch_en && p_sw) t_sw_f = cyc;
      if (domain_rst && !p_rst)   t_rst_r = cyc;
      if (!domain_rst && p_rst)   t_rst_f = cyc;
      if (clamp_en && !p_cl)      t_cl_r = cyc;
      if (!clamp_en && p_cl)      t_cl_f = cyc;
      if (clk_en && !p_ck)        t_ck_r = cyc;
      if (!clk_en && p_ck)        t_ck_f = cyc;
      if (retain_en && !p_rt)     t_rt_r = cyc;
      if (!retain_en && p_rt)     t_rt_f = cyc;
      if (retain_en) rt_high++;
      if (reg_addr == 3'd4 && reg_rdata[15] && reg_rdata[16]) both_flags++;
    end
    p_sw = pwr_switch_en; p_rst = domain_rst; p_cl = clamp_en;
    p_ck = clk_en; p_rt = retain_en;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 3'd4;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 3'd4;
  endtask

  // Counts clock edges after the write edge until a status bit is seen
  task automatic wait_bit(input int pos, input int maxc, output int n);
    bit ok;
    n = 0; ok = 0;
    while (n < maxc && !ok) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (reg_rdata[pos]) ok = 1;
    end
    if (!ok) n = -1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d);
    chk("R1 control reset value", d, 32'h0000_2001);
    chk("R1 outputs off", {pwr_switch_en, clamp_en, domain_rst, clk_en, retain_en}, 5'b01100);
    rd(3'd4, d);
    chk("R6 down flag after reset", d, 32'h0000_8000);
  endtask

  task automatic t_sw_up();
    int n;
    wr(3'd0, 32'h0000_2000);
    wait_bit(16, 60, n);
    chk("R2 R4 up completes in 1+5*(w+1)", n, 16);
    chk("R4 reset release after switch", t_rst_f - t_sw_r, 3);
    chk("R4 clamp release after reset", t_cl_f - t_rst_f, 6);
    chk("R4 clock on after clamp", t_ck_r - t_cl_f, 3);
    chk("R6 status word when on", reg_rdata, 32'h0001_0000);
  endtask

  task automatic t_down_retain();
    int n;
    wr(3'd0, 32'h0000_2801);
    wait_bit(15, 60, n);
    chk("R2 R3 down completes in 1+5*(w+1)", n, 16);
    chk("R3 clamp after clock gate", t_cl_r - t_ck_f, 3);
    chk("R3 retain after clamp", t_rt_r - t_cl_r, 3);
    chk("R3 reset after retain", t_rst_r - t_rt_r, 3);
    chk("R3 switch off after reset", t_sw_f - t_rst_r, 3);
    chk("R5 retain held when off", retain_en, 1);
  endtask

  task automatic t_up_retain();
    int n;
    wr(3'd0, 32'h0000_2800);
    wait_bit(16, 60, n);
    chk("R4 up with retain", n, 16);
    chk("R5 retain released after reset release", t_rt_f - t_rst_f, 3);
    chk("R5 retain low when on", retain_en, 0);
  endtask

  task automatic t_fast_no_retain();
    int n;
    rt_high = 0;
    wr(3'd0, 32'h0000_0001);
    wait_bit(15, 60, n);
    chk("R3 zero wait down", n, 6);
    chk("R3 zero wait spacing", t_sw_f - t_ck_f, 4);
    chk("R5 retain stays low when disabled", rt_high, 0);
  endtask

  task automatic t_ack_stall();
    int n;
    ack_block = 1'b1;
    wr(3'd0, 32'h0000_0000);
    repeat (30) @(negedge clk);
    chk("R4 stall keeps reset and switch", {pwr_switch_en, domain_rst}, 2'b11);
    chk("R4 stall no flag", reg_rdata, 0);
    ack_block = 1'b0;
    wait_bit(16, 20, n);
    chk("R4 completes after ack", n > 0, 1);
  endtask

  task automatic t_override();
    int n;
    wr(3'd0, 32'h0000_0005);
    repeat (30) @(negedge clk);
    chk("R8 hold keeps domain on", {clk_en, reg_rdata}, {1'b1, 32'h0001_0000});
    wr(3'd0, 32'h0000_0001);
    wait_bit(15, 20, n);
    chk("R8 release lets collapse run", n, 6);
  endtask

  task automatic t_midseq();
    int n, m;
    wr(3'd0, 32'h0000_2000);
    @(negedge clk); @(negedge clk);
    wr(3'd0, 32'h0000_2001);
    chk("R9 no reversal mid-sequence", {pwr_switch_en, clamp_en}, 2'b11);
    wait_bit(16, 40, n);
    chk("R9 up sequence completes", n > 0, 1);
    wait_bit(15, 40, m);
    chk("R9 latched collapse then runs", m, 16);
  endtask

  task automatic t_hw_mode();
    int n;
    hw_collapse_req = 1'b1;
    wr(3'd0, 32'h0000_2002);
    repeat (30) @(negedge clk);
    chk("R7 collapse bit ignored in hw mode", reg_rdata, 32'h0000_8000);
    hw_collapse_req = 1'b0;
    wait_bit(16, 40, n);
    chk("R7 trigger low powers up", n, 16);
    wr(3'd0, 32'h0000_2003);
    repeat (30) @(negedge clk);
    chk("R7 collapse bit 1 ignored", reg_rdata, 32'h0001_0000);
  endtask

  task automatic t_mode_switch();
    int start, k;
    bit saw_low, high_again;
    wr(3'd0, 32'h0000_2000);
    repeat (5) @(negedge clk);
    hw_collapse_req = 1'b1;
    start = cyc;
    wr(3'd0, 32'h0000_2002);
    reg_addr = 3'd0;
    saw_low = 0; high_again = 0; k = 0;
    while (k < 100 && !high_again) begin
      @(negedge clk); k++;
      if (k == 5) hw_collapse_req = 1'b0;
      if (!reg_rdata[31]) saw_low = 1;
      else if (saw_low) high_again = 1;
    end
    reg_addr = 3'd4;
    chk("R11 power-on dropped", saw_low, 1);
    chk("R11 restored after cycle", high_again, 1);
    chk("R11 switch went off during cycle", t_sw_f > start, 1);
    chk("R11 switch back on before power-on", t_sw_r > t_sw_f, 1);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(3'd0, 32'h0000_7806);
    rd(3'd0, d);
    chk("R10 readback with live power-on", d, 32'h8000_7806);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd0, d);
    chk("R10 status write ignored (control)", d, 32'h8000_7806);
    rd(3'd4, d);
    chk("R10 status write ignored (status)", d, 32'h0001_0000);
    chk("R6 flags never both set", both_flags, 0);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 3'd4; reg_wdata = '0;
    hw_collapse_req = 1'b0; ack_block = 1'b0;
    t_sw_r = 0; t_sw_f = 0; t_rst_r = 0; t_rst_f = 0; t_cl_r = 0; t_cl_f = 0;
    t_ck_r = 0; t_ck_f = 0; t_rt_r = 0; t_rt_f = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_sw_up();
    t_down_retain();
    t_up_retain();
    t_fast_no_retain();
    t_ack_stall();
    t_override();
    t_midseq();
    t_hw_mode();
    t_mode_switch();
    t_regs();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule